// File: doc/BRIEF.md
# Ripple-Carry Integer ALU with Signed Overflow

This block is a combinational integer ALU for a simple processor datapath. Each result bit comes from its own slice. A slice holds a full adder, a bitwise AND, OR and XOR, and an optional inversion of the second operand. The carry passes from slice to slice, so the adder is a true ripple chain. The operation select picks one of five outputs in every slice. The subtract and compare modes come from the invert control together with the carry-in.

Three flags are produced next to the result:
- the carry out of the top slice;
- a zero flag;
- a signed overflow flag, taken from the carry into and out of the top slice.

The set-less-than mode does not use the raw sign of the difference. It feeds the sign bit XOR overflow back into the bottom slice, so the signed compare stays correct when the subtraction overflows. Every other slice returns 0 in that mode.

Top module: `ripple_alu`

## Requirements
- R1: With op_sel = 0 the result is a AND b, bitwise. b_invert does not affect it.
- R2: With op_sel = 1 the result is a OR b, bitwise. b_invert does not affect it.
- R3: With op_sel = 2 and b_invert = 0 the result is the low WIDTH bits of a + b + carry_in. carry_out is the carry out of the top bit.
- R4: With op_sel = 2, b_invert = 1 and carry_in = 1 the result is a - b. carry_out is the carry of a + ~b + 1, which is 1 when there is no borrow.
- R5: With op_sel = 3 the result is a XOR b, whatever the values of b_invert and carry_in.
- R6: overflow is 1 exactly when the adder's signed sum a + (b_invert ? ~b : b) + carry_in overflows. This holds in every mode. For addition that means equal operand signs and a sum sign that differs from them. For subtraction it means different operand signs and a difference sign that differs from a's sign.
- R7: With op_sel = 4, b_invert = 1 and carry_in = 1, result bit 0 is 1 exactly when a < b as signed numbers, also when a - b overflows. All other result bits are 0. Examples: a = 0x80000000 and b = 1 give 1; a = 0x7FFFFFFF and b = 0xFFFFFFFF give 0.
- R8: zero is 1 exactly when all result bits are 0.
- R9: With op_sel = 5, 6 or 7 the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| b_invert | input | 1 | Invert b before the adder (1 = subtract / compare) |
| carry_in | input | 1 | Carry into bit 0 |
| op_sel | input | 3 | 0 AND, 1 OR, 2 adder, 3 XOR, 4 set-less-than, others 0 |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Carry out of the top slice |
| zero | output | 1 | All result bits are 0 |
| overflow | output | 1 | Signed overflow of the adder |

## Verification
The bench builds the ALU with the default WIDTH of 32. At that width the sign-boundary operands are reachable by name: 0x80000000, 0x7FFFFFFF, 0xFFFFFFFF and 0. Adding and subtracting these drives the carry into the top slice and the carry out of it apart. That is the case where a raw-sign compare gives the wrong answer. Random operands across all eight select codes then cover long carry ripples and the zero flag.

// File: rtl/ripple_alu.sv
module ripple_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             b_invert,
  input  logic             carry_in,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             zero,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;

  logic set_bit;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic ci, co, bb, sum, lt, r;
    if (i == 0) begin : g_lsb
      assign ci = carry_in;
      assign lt = set_bit;
    end else begin : g_up
      assign ci = g_bit[i-1].co;
      assign lt = 1'b0;
    end
    assign bb  = b_invert ? ~b[i] : b[i];
    assign sum = a[i] ^ bb ^ ci;
    assign co  = (a[i] & bb) | (a[i] & ci) | (bb & ci);
    assign r   = (op_sel == 3'd0) ? (a[i] & b[i]) :
                 (op_sel == 3'd1) ? (a[i] | b[i]) :
                 (op_sel == 3'd2) ? sum :
                 (op_sel == 3'd3) ? (a[i] ^ b[i]) :
                 (op_sel == 3'd4) ? lt : 1'b0;
    assign result[i] = r;
  end

  assign carry_out = g_bit[MSB].co;
  assign overflow  = g_bit[MSB].ci ^ g_bit[MSB].co;
  assign set_bit   = g_bit[MSB].sum ^ overflow;
  assign zero      = ~|result;
endmodule

// File: rtl/ripple_alu_chk.sv
module ripple_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             b_invert,
  input logic             carry_in,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             zero,
  input logic             overflow
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    // R5
    if (op_sel == 3'd3) xor_result_chk: assert (result == (a ^ b));
    // R3
    if (op_sel == 3'd2 && !b_invert)
      add_sum_chk: assert ({carry_out, result} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, carry_in}));
    // R6
    if (op_sel == 3'd2)
      sign_ovf_chk: assert (overflow == (b_invert ? ((a[MSB] != b[MSB]) && (result[MSB] != a[MSB]))
                                                  : ((a[MSB] == b[MSB]) && (result[MSB] != a[MSB]))));
    // R7
    if (op_sel == 3'd4 && b_invert && carry_in)
      slt_signed_chk: assert (result == {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))});
    // R8
    if (op_sel == 3'd0 && (a & b) == '0) and_zero_chk: assert (zero);
  end
endmodule

bind ripple_alu ripple_alu_chk #(.WIDTH(WIDTH)) chk_i (
  .a(a), .b(b), .b_invert(b_invert), .carry_in(carry_in), .op_sel(op_sel),
  .result(result), .carry_out(carry_out), .zero(zero), .overflow(overflow)
);

// File: tb/ripple_alu_tb_top.sv
`timescale 1ns/1ps
module ripple_alu_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, result;
  logic b_invert, carry_in, carry_out, zero, overflow;
  logic [2:0] op_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W+2:0] exp_q[$];
  string        tag_q[$];

  ripple_alu #(.WIDTH(W)) dut_i (
    .a(a), .b(b), .b_invert(b_invert), .carry_in(carry_in), .op_sel(op_sel),
    .result(result), .carry_out(carry_out), .zero(zero), .overflow(overflow)
  );

  function automatic logic [W+2:0] model(logic [W-1:0] x, logic [W-1:0] y,
                                         logic inv, logic ci, logic [2:0] op);
    logic [W-1:0] yb, r;
    logic [W:0] full;
    logic ov;
    yb   = inv ? ~y : y;
    full = {1'b0, x} + {1'b0, yb} + {{W{1'b0}}, ci};
    ov   = (x[W-1] == yb[W-1]) && (full[W-1] != x[W-1]);
    case (op)
      3'd0: r = x & y;
      3'd1: r = x | y;
      3'd2: r = full[W-1:0];
      3'd3: r = x ^ y;
      3'd4: r = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
      default: r = '0;
    endcase
    return {r, full[W], (r == '0), ov};
  endfunction

  task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic inv, logic ci,
                       logic [2:0] op, string tag);
    @(posedge clk);
    a = x; b = y; b_invert = inv; carry_in = ci; op_sel = op;
    exp_q.push_back(model(x, y, inv, ci, op));
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [W+2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({result, carry_out, zero, overflow} !== e) begin
          fails++;
          $display("FAIL %s: actual res=%h co=%b z=%b ov=%b expected res=%h co=%b z=%b ov=%b",
                   t, result, carry_out, zero, overflow, e[W+2:3], e[2], e[1], e[0]);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; b_invert = 1'b0; carry_in = 1'b0; op_sel = 3'd0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive('0, '0, 0, 0, 3'd0, "R8 all-zero inputs");
    drive(32'hF0F0_1234, 32'h0FF0_FFFF, 1, 0, 3'd0, "R1 and, invert ignored");
    drive(32'hF000_000F, 32'h0F00_00F0, 1, 1, 3'd1, "R2 or, invert ignored");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 3'd2, "R3 add full ripple carry");
    drive(32'h1234_5678, 32'h1111_1111, 0, 1, 3'd2, "R3 add with carry_in");
    drive(32'h0000_0005, 32'h0000_0007, 1, 1, 3'd2, "R4 sub with borrow");
    drive(32'h0000_0009, 32'h0000_0009, 1, 1, 3'd2, "R4 R8 sub equal gives zero");
    drive(32'hA5A5_A5A5, 32'h5A5A_FFFF, 1, 1, 3'd3, "R5 xor, invert and cin ignored");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 3'd2, "R6 add positive overflow");
    drive(32'h8000_0000, 32'h8000_0000, 0, 0, 3'd2, "R6 add negative overflow");
    drive(32'h8000_0000, 32'h0000_0001, 1, 1, 3'd2, "R6 sub overflow");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 1, 3'd2, "R6 sub overflow positive");
    drive(32'h8000_0000, 32'h0000_0001, 1, 1, 3'd4, "R7 slt min vs 1");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 1, 3'd4, "R7 slt max vs -1");
    drive(32'hFFFF_FFFE, 32'hFFFF_FFFF, 1, 1, 3'd4, "R7 slt negatives");
    drive(32'h0000_0003, 32'h0000_0003, 1, 1, 3'd4, "R7 R8 slt equal");
    drive(32'hDEAD_BEEF, 32'h1234_5678, 0, 1, 3'd5, "R9 op 5 zero");
    drive(32'hDEAD_BEEF, 32'h1234_5678, 1, 0, 3'd6, "R9 op 6 zero");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 3'd7, "R9 op 7 zero");
    for (int k = 0; k < 2000; k++) begin
      logic [2:0] op;
      logic inv, ci;
      op  = 3'($urandom_range(0, 7));
      inv = 1'($urandom);
      ci  = 1'($urandom);
      if (op == 3'd4) begin inv = 1'b1; ci = 1'b1; end
      drive($urandom, (k % 7 == 0) ? 32'($urandom_range(0, 3)) : $urandom, inv, ci, op,
            "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule